// File: doc/BRIEF.md
# Random Generator Register Front-End

This block is the register-side front end of a random number peripheral. Software reaches it over a simple word-addressed bus with three 32-bit registers: control at offset 0x00, status at 0x04 and data at 0x08. An external entropy source pushes 32-bit words into a small output queue through a valid/ready port and reports failures on a one-cycle seed-error strobe. The front end tells the source when to run and which noise-clock divide exponent to use. It also raises a level interrupt.

Seed failures are tracked by two flags. A sticky error flag is kept until software clears it. A live error flag shows that the generator is stopped. Recovery from a seed error is chosen at elaboration time. One option is a conditional reset sequence that clears itself. Another is a flush that counts a fixed number of discarded data reads. A third, the auto-recovery option, clears the live flag after a fixed delay. Words still queued when an error strikes are overwritten with zero, so software sees an all-zero word as the error marker.

Top module: `rng_regfront`

## Requirements
- R1: After reset the control and status registers read 0x00000000, and `gen_run`, `irq` and `noise_div` are 0.
- R2: A write to control updates run enable (bit 2), interrupt enable (bit 3) and clock-check disable (bit 5), and these read back from control. `gen_run` is high while run enable is 1, no live seed error is present and no conditional reset is in progress.
- R3: With conditional reset present, the configuration field (control bits 25:8) is updated only by a control write that also has bit 30 set. Other control writes leave it unchanged. The divide exponent in bits 19:16 is driven on `noise_div`.
- R4: The queue holds up to 4 words. `ent_ready` is high while `gen_run` is high, the queue is not full and no seed-error strobe is present. Data reads return the queued words oldest first. Status bit 0 (data ready) is 1 exactly when at least one word is queued.
- R5: A data read on an empty queue returns 0x00000000 and leaves the queue unchanged.
- R6: A seed-error strobe while `gen_run` is high sets status bit 6 (sticky error) and bit 2 (live error). It drops `gen_run` and `ent_ready` until recovery completes.
- R7: Words queued when a seed error occurs read back as 0x00000000. They still count toward data ready.
- R8: With conditional reset present, writing control bit 30 as 1 holds the block in reset and empties the queue. A later write of bit 30 as 0 starts a reset cycle of RST_CYCLES clocks. Bit 30 reads 1 until that cycle ends, and then the live error clears and generation resumes.
- R9: Status bit 6 clears when a status write carries 0 in that bit. A 1 leaves it unchanged. All other status bits are unaffected by status writes.
- R10: `irq` is high exactly when interrupt enable and the sticky error flag are both 1.
- R11: Without conditional reset, control bit 30 reads 0 and every control write updates the configuration field. After a seed error the live flag clears, and the queue empties, on the FLUSH_WORDS-th data read (12 by default).
- R12: With auto-recovery selected, the live error clears by itself RST_CYCLES clocks after the error and the queue empties. The sticky error stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the access |
| ent_valid | input | 1 | Entropy word offered |
| ent_word | input | 32 | Entropy word |
| ent_ready | output | 1 | Entropy word accepted when high with ent_valid |
| seed_err | input | 1 | Seed-error strobe from the source |
| gen_run | output | 1 | Source is allowed to generate |
| noise_div | output | 4 | Noise-clock divide exponent (divide by 2^n) |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets three corner cases. The first is a full queue and an empty-queue read. A design with an off-by-one count would accept a fifth word or wrap its read pointer and return stale data. The second is a configuration write without the reset bit. A design that ignored the qualifier would change `noise_div`. The third is the set of recovery paths, each run on its own instance. A design that cleared the sticky flag on a write of 1, cleared the live flag one read early in flush mode, or ended the reset cycle early would fail the exact status and readback values the bench expects at those cycles.

// File: rtl/rng_pkg.sv
package rng_pkg;
   // register byte offsets
   localparam logic [3:0] OFF_CTRL = 4'h0;
   localparam logic [3:0] OFF_STAT = 4'h4;
   localparam logic [3:0] OFF_DATA = 4'h8;

   // control bit positions
   localparam int CB_EN    = 2;
   localparam int CB_IE    = 3;
   localparam int CB_CED   = 5;
   localparam int CB_CRST  = 30;
   localparam int CFG_LO   = 8;
   localparam int CFG_HI   = 25;
   localparam int CFG_W    = CFG_HI - CFG_LO + 1;
   localparam int DIV_LO   = 16;
   localparam int DIV_W    = 4;

   // status bit positions
   localparam int SB_SEIS  = 6;

   typedef enum logic [1:0] {CR_IDLE, CR_HELD, CR_BUSY} crst_state_e;
endpackage

// File: rtl/rng_word_fifo.sv
module rng_word_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   input  logic         zero_all,
   input  logic         clear,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("rng_word_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (clear) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (zero_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (push) begin
            mem[wr_ptr] <= din;
         end
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   assign dout  = mem[rd_ptr];
   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
   p_level_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !clear) |=> count == $past(count) + 1'b1);
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);
endmodule

// File: rtl/rng_seed_recover.sv
module rng_seed_recover
   import rng_pkg::*;
#(
   parameter bit HAS_CONDRST = 1'b1,
   parameter bit AUTO_RESET  = 1'b0,
   parameter int RST_CYCLES  = 8,
   parameter int FLUSH_WORDS = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic err_evt,
   input  logic cr_wr,
   input  logic cr_bit,
   input  logic data_rd,
   output logic secs,
   output logic rst_busy,
   output logic hold,
   output logic done
);
   localparam int TW = $clog2(RST_CYCLES + 1);
   localparam int FW = $clog2(FLUSH_WORDS + 1);

   initial begin
      assert (RST_CYCLES >= 1 && FLUSH_WORDS >= 1)
         else $error("rng_seed_recover: cycle counts must be >= 1");
   end

   logic done_c, done_f, done_a, hold_c;

   generate
      if (HAS_CONDRST) begin : g_cond
         crst_state_e   st;
         logic [TW-1:0] tmr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st  <= CR_IDLE;
               tmr <= '0;
            end else begin
               case (st)
                  CR_IDLE: if (cr_wr && cr_bit) st <= CR_HELD;
                  CR_HELD: if (cr_wr && !cr_bit) begin
                     st  <= CR_BUSY;
                     tmr <= TW'(RST_CYCLES - 1);
                  end
                  CR_BUSY: begin
                     if (cr_wr && cr_bit)  st  <= CR_HELD;
                     else if (tmr == '0)   st  <= CR_IDLE;
                     else                  tmr <= tmr - 1'b1;
                  end
                  default: st <= CR_IDLE;
               endcase
            end
         end
         assign done_c = (st == CR_BUSY) && (tmr == '0) && !(cr_wr && cr_bit);
         assign hold_c = (st != CR_IDLE);

         p_busy_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (st == CR_HELD && cr_wr && !cr_bit) |=> rst_busy);
      end else begin : g_nocond
         assign done_c = 1'b0;
         assign hold_c = 1'b0;
      end

      if (!HAS_CONDRST) begin : g_flush
         logic [FW-1:0] fcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                fcnt <= '0;
            else if (err_evt || done)  fcnt <= '0;
            else if (secs && data_rd)  fcnt <= fcnt + 1'b1;
         end
         assign done_f = secs && data_rd && (fcnt == FW'(FLUSH_WORDS - 1));
      end else begin : g_noflush
         assign done_f = 1'b0;
      end

      if (AUTO_RESET) begin : g_auto
         logic [TW-1:0] atmr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        atmr <= '0;
            else if (!secs || hold_c || done)  atmr <= '0;
            else                               atmr <= atmr + 1'b1;
         end
         assign done_a = secs && !hold_c && (atmr == TW'(RST_CYCLES - 1));
      end else begin : g_noauto
         assign done_a = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        secs <= 1'b0;
      else if (err_evt)  secs <= 1'b1;
      else if (done)     secs <= 1'b0;
   end

   assign done     = done_c | done_f | done_a;
   assign hold     = hold_c;
   assign rst_busy = hold_c;

   p_err_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |=> secs);
endmodule

// File: rtl/rng_regfront.sv
module rng_regfront
   import rng_pkg::*;
#(
   parameter int FIFO_WORDS  = 4,
   parameter bit HAS_CONDRST = 1'b1,
   parameter bit AUTO_RESET  = 1'b0,
   parameter int RST_CYCLES  = 8,
   parameter int FLUSH_WORDS = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [3:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        ent_valid,
   input  logic [31:0] ent_word,
   output logic        ent_ready,
   input  logic        seed_err,
   output logic        gen_run,
   output logic [3:0]  noise_div,
   output logic        irq
);
   localparam int DW = 32;

   logic             cr_en, cr_ie, cr_ced, seis;
   logic [CFG_W-1:0] cfg;
   logic             wr_ctrl, wr_stat, rd_any, rd_data, cfg_take;
   logic             secs, rst_busy, hold, done, err_evt;
   logic             f_empty, f_full, f_push, f_pop;
   logic [DW-1:0]    f_dout, rd_mux;

   assign wr_ctrl = bus_sel && bus_wr && (bus_addr == OFF_CTRL);
   assign wr_stat = bus_sel && bus_wr && (bus_addr == OFF_STAT);
   assign rd_any  = bus_sel && !bus_wr;
   assign rd_data = rd_any && (bus_addr == OFF_DATA);

   generate
      if (HAS_CONDRST) begin : g_cfg_gated
         assign cfg_take = bus_wdata[CB_CRST];
      end else begin : g_cfg_open
         assign cfg_take = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cr_en  <= 1'b0;
         cr_ie  <= 1'b0;
         cr_ced <= 1'b0;
         cfg    <= '0;
      end else if (wr_ctrl) begin
         cr_en  <= bus_wdata[CB_EN];
         cr_ie  <= bus_wdata[CB_IE];
         cr_ced <= bus_wdata[CB_CED];
         if (cfg_take) cfg <= bus_wdata[CFG_HI:CFG_LO];
      end
   end

   assign gen_run = cr_en && !secs && !hold;
   assign err_evt = seed_err && gen_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 seis <= 1'b0;
      else if (err_evt)                           seis <= 1'b1;
      else if (wr_stat && !bus_wdata[SB_SEIS])    seis <= 1'b0;
   end

   rng_seed_recover #(
      .HAS_CONDRST (HAS_CONDRST),
      .AUTO_RESET  (AUTO_RESET),
      .RST_CYCLES  (RST_CYCLES),
      .FLUSH_WORDS (FLUSH_WORDS)
   ) recover_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .err_evt  (err_evt),
      .cr_wr    (wr_ctrl),
      .cr_bit   (bus_wdata[CB_CRST]),
      .data_rd  (rd_data),
      .secs     (secs),
      .rst_busy (rst_busy),
      .hold     (hold),
      .done     (done)
   );

   assign ent_ready = gen_run && !f_full && !seed_err;
   assign f_push    = ent_valid && ent_ready;
   assign f_pop     = rd_data && !f_empty;

   rng_word_fifo #(.W(DW), .DEPTH(FIFO_WORDS)) fifo_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (f_push),
      .din      (ent_word),
      .pop      (f_pop),
      .zero_all (err_evt),
      .clear    (hold || done),
      .dout     (f_dout),
      .empty    (f_empty),
      .full     (f_full)
   );

   always_comb begin
      case (bus_addr)
         OFF_CTRL: rd_mux = {1'b0, rst_busy, 4'b0, cfg, 2'b0, cr_ced, 1'b0, cr_ie, cr_en, 2'b0};
         OFF_STAT: rd_mux = {25'b0, seis, 2'b0, 1'b0, secs, 1'b0, !f_empty};
         OFF_DATA: rd_mux = f_empty ? '0 : f_dout;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_any) bus_rdata <= rd_mux;
   end

   assign noise_div = cfg[DIV_LO-CFG_LO +: DIV_W];
   assign irq       = cr_ie && seis;

   p_err_sets_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_err && gen_run) |=> (seis && !gen_run && !ent_ready));
   p_cfg_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_CONDRST && wr_ctrl && !bus_wdata[CB_CRST]) |=> $stable(cfg));
   p_seis_w1_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && bus_wdata[SB_SEIS] && seis) |=> seis);
   p_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
      secs |-> !ent_ready);
   p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !seis |-> !irq);
endmodule

// File: tb/rng_regfront_tb_top.sv
module rng_regfront_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        ent_valid = 1'b0;
   logic [31:0] ent_word = '0;
   logic        seed_err = 1'b0;

   logic [31:0] rd_a, rd_b, rd_c;
   logic        rdy_a, rdy_b, rdy_c, run_a, run_b, run_c, irq_a, irq_b, irq_c;
   logic [3:0]  div_a, div_b, div_c;

   int total = 0, bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   rng_regfront dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd_a), .ent_valid(ent_valid), .ent_word(ent_word),
      .ent_ready(rdy_a), .seed_err(seed_err), .gen_run(run_a), .noise_div(div_a), .irq(irq_a));

   rng_regfront #(.HAS_CONDRST(1'b0)) dut_flush_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd_b), .ent_valid(ent_valid), .ent_word(ent_word),
      .ent_ready(rdy_b), .seed_err(seed_err), .gen_run(run_b), .noise_div(div_b), .irq(irq_b));

   rng_regfront #(.AUTO_RESET(1'b1)) dut_auto_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rd_c), .ent_valid(ent_valid), .ent_word(ent_word),
      .ent_ready(rdy_c), .seed_err(seed_err), .gen_run(run_c), .noise_div(div_c), .irq(irq_c));

   localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_DATA = 4'h8;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic push(input logic [31:0] w);
      ent_valid = 1'b1; ent_word = w;
      @(negedge clk);
      ent_valid = 1'b0;
   endtask

   function automatic logic [31:0] next_word(input logic [31:0] w);
      return (w == 32'h0) ? 32'h1 : w;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog got=%h exp=%h", 32'h0, 32'h1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] q[$];
      logic [31:0] w, exp;
      void'($urandom(32'd4242));
      do_reset();

      // R1 reset state
      rd(A_CTRL); chk("R1 ctrl", rd_a, 0); chk("R1 ctrl flush", rd_b, 0);
      rd(A_STAT); chk("R1 stat", rd_a, 0); chk("R1 stat auto", rd_c, 0);
      chk("R1 pins", {run_a, irq_a, div_a}, 0);

      // R2 control bits
      wr(A_CTRL, 32'h0000_002C);
      rd(A_CTRL); chk("R2 ctrl readback", rd_a, 32'h0000_002C);
      chk("R2 gen_run", run_a, 1);
      wr(A_CTRL, 32'h0000_000C);
      rd(A_CTRL); chk("R2 ced cleared", rd_a, 32'h0000_000C);

      // R3 config gating, R11 open config on flush variant
      wr(A_CTRL, 32'h0005_000C);
      rd(A_CTRL); chk("R3 cfg ignored", rd_a, 32'h0000_000C);
      chk("R11 cfg open", rd_b, 32'h0005_000C);
      chk("R3 div unchanged", div_a, 0); chk("R11 div", div_b, 5);
      wr(A_CTRL, 32'h4005_000C);
      rd(A_CTRL); chk("R3 cfg taken + held", rd_a, 32'h4005_000C);
      chk("R11 bit30 reads 0", rd_b, 32'h0005_000C);
      chk("R8 held stops run", run_a, 0);
      chk("R3 div", div_a, 5);
      wr(A_CTRL, 32'h0000_000C);
      rd(A_CTRL); chk("R8 busy after release", rd_a, 32'h4005_000C);
      repeat (9) @(negedge clk);
      rd(A_CTRL); chk("R8 busy ends", rd_a, 32'h0005_000C);
      chk("R8 run resumes", run_a, 1);

      // R4/R5 random traffic on all three instances
      do_reset();
      wr(A_CTRL, 32'h0000_000C);
      for (int i = 0; i < 80; i++) begin
         if ($urandom_range(0, 2) != 0) begin
            w = next_word($urandom);
            chk("R4 ready", {31'b0, rdy_a}, {31'b0, q.size() < 4});
            if (q.size() < 4) q.push_back(w);
            push(w);
         end else begin
            exp = (q.size() != 0) ? q.pop_front() : 32'h0;
            rd(A_DATA);
            chk("R4 data", rd_a, exp); chk("R4 data flush", rd_b, exp); chk("R4 data auto", rd_c, exp);
            rd(A_STAT); chk("R4 drdy", rd_a, {31'b0, q.size() != 0});
         end
      end
      while (q.size() != 0) begin
         exp = q.pop_front();
         rd(A_DATA); chk("R4 drain", rd_a, exp);
      end
      // directed: full boundary, then empty read
      for (int i = 0; i < 4; i++) push(32'h1000_0000 + i);
      chk("R4 full no ready", rdy_a, 0);
      push(32'hDEAD_BEEF);
      for (int i = 0; i < 4; i++) begin
         rd(A_DATA); chk("R4 order", rd_a, 32'h1000_0000 + i);
      end
      rd(A_DATA); chk("R5 empty read", rd_a, 0);
      rd(A_STAT); chk("R5 drdy low", rd_a, 0);
      push(32'h0BAD_F00D);
      rd(A_DATA); chk("R5 fifo intact", rd_a, 32'h0BAD_F00D);

      // R6/R7/R10 seed error
      push(32'hA5A5_0001); push(32'hA5A5_0002);
      seed_err = 1'b1; @(negedge clk); seed_err = 1'b0;
      rd(A_STAT); chk("R6 status", rd_a, 32'h45); chk("R6 status flush", rd_b, 32'h45);
      chk("R6 status auto", rd_c, 32'h45);
      chk("R6 stopped", {run_a, rdy_a}, 0);
      chk("R10 irq", irq_a, 1);
      rd(A_DATA); chk("R7 zeroed 1", rd_a, 0);
      rd(A_DATA); chk("R7 zeroed 2", rd_a, 0);
      repeat (10) @(negedge clk);
      rd(A_STAT); chk("R12 auto recovered", rd_c, 32'h40); chk("R6 live stays", rd_a, 32'h04 | 32'h40);
      chk("R12 auto run", run_c, 1);

      // R9 write-0-to-clear
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT); chk("R9 w1 keeps", rd_a, 32'h44);
      chk("R10 irq held", irq_a, 1);
      wr(A_STAT, 32'h0);
      rd(A_STAT); chk("R9 w0 clears", rd_a, 32'h04); chk("R9 auto", rd_c, 32'h00);
      chk("R10 irq low", irq_a, 0);

      // R11 flush: 2 reads done, 9 more, then the 12th
      for (int i = 0; i < 9; i++) rd(A_DATA);
      rd(A_STAT); chk("R11 still live", rd_b, 32'h04);
      rd(A_DATA);
      rd(A_STAT); chk("R11 flushed", rd_b, 32'h00); chk("R11 run", run_b, 1);

      // R8 conditional reset recovery
      wr(A_CTRL, 32'h4000_000C);
      wr(A_CTRL, 32'h0000_000C);
      rd(A_CTRL); chk("R8 bit30 busy", rd_a, 32'h4000_000C);
      rd(A_STAT); chk("R8 live during reset", rd_a, 32'h04);
      repeat (10) @(negedge clk);
      rd(A_STAT); chk("R8 live cleared", rd_a, 32'h00);
      chk("R8 run", run_a, 1);
      push(32'h5555_AAAA);
      rd(A_DATA); chk("R8 resumed", rd_a, 32'h5555_AAAA);
      chk("R11 resumed", rd_b, 32'h5555_AAAA); chk("R12 resumed", rd_c, 32'h5555_AAAA);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule